// File: doc/BRIEF.md
# Divided-rate two-stage synchroniser

This block brings one asynchronous bit into a fast clock domain. A capture flop samples the input on every fast-clock rising edge. Its output feeds a two-flop synchronising chain that advances only once every N fast-clock cycles. Each chain stage therefore gets N fast periods to settle instead of one. The price is latency: a change reaches the output between N+1 and 2N fast edges after it is captured.

The reduced rate is not a derived clock. A modulo-N counter on the fast clock raises a one-cycle enable, the chain flops load on the fast edge that ends an enabled cycle, and so every divided edge is also a fast edge. N is set at run time. A new value is picked up only when the counter wraps, so no enable period is ever cut short or doubled. The enable is also driven out as a strobe, which lets the surrounding logic or a bench relate output changes to the divided timing.

Top module: `divrate_sync`

## Requirements
- R1: The input is registered on every fast-clock rising edge, not only on divided edges. With N=4, a one-cycle input pulse reaches the output if it is captured on the fast edge just before a divided edge. It is lost if a divided edge came on the edge that captured it.
- R2: `sync_o` changes only on a fast edge that ends a cycle in which `tick_o` was high.
- R3: `div_sel_i` is read as an unsigned ratio N. The values 2 up to 2^DIV_W-1 give a `tick_o` period of exactly N fast cycles, and the values 0 and 1 act as 2.
- R4: `tick_o` is high for exactly one fast cycle in each period, and never in two consecutive cycles.
- R5: Let an input change be captured on fast edge E0. The output takes the new value on fast edge E(j+N), where E(j) is the first divided edge after E0 (1 ≤ j ≤ N). The total latency is therefore N+1 to 2N edges. With N=4 this is 5 to 8 edges after E0, and it grows with N.
- R6: Counting E0 as the 1st edge, N=4 gives this mapping. A first divided edge on the 2nd, 3rd, 4th or 5th edge puts the output update on the 6th, 7th, 8th or 9th edge.
- R7: A change to `div_sel_i` takes effect only at the next counter wrap. The period in progress finishes at the old ratio, and the following period uses the new one.
- R8: While `rst_ni` is low, the capture flop, both chain flops and the counter are held at zero, and `sync_o` and `tick_o` are low. The ratio in force after reset is 4. After release, `tick_o` first goes high in the cycle after the third fast rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| async_i | input | 1 | Asynchronous data bit |
| div_sel_i | input | DIV_W | Division ratio N (0 and 1 act as 2) |
| sync_o | output | 1 | Synchronised data |
| tick_o | output | 1 | Divided-rate enable strobe, one fast cycle wide |

## Verification
A wrong counter or ratio register shows up at `tick_o` within one divided period, as a spacing other than N or as a late switch after a setting change. A wrong chain stage shows up at `sync_o`: it moves outside a cycle that follows a tick, or it moves on an edge other than E(j+N). This is visible within 2N+1 fast cycles of the input change. A capture flop gated by the tick is exposed by single-cycle pulses: a pulse that should pass is lost.

// File: rtl/divrate_sync.sv
module divrate_sync #(
  parameter int DIV_W   = 3,
  parameter int RST_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             async_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             sync_o,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] MinDiv = DIV_W'(2);
  localparam logic [DIV_W-1:0] RstDiv = DIV_W'(RST_DIV);

  logic [DIV_W-1:0] cnt_q, ratio_q, sel_ok;
  logic             cap_q, mid_q, out_q, wrap;

  assign sel_ok = (div_sel_i < MinDiv) ? MinDiv : div_sel_i;
  assign wrap   = (cnt_q == ratio_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RstDiv;
    end else if (wrap) begin
      cnt_q   <= '0;
      ratio_q <= sel_ok;
    end else begin
      cnt_q   <= cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= async_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q <= 1'b0;
      out_q <= 1'b0;
    end else if (wrap) begin
      mid_q <= cap_q;
      out_q <= mid_q;
    end
  end

  assign sync_o = out_q;
  assign tick_o = wrap;

endmodule

// File: rtl/divrate_sync_chk.sv
module divrate_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic async_i,
  input logic tick_o,
  input logic sync_o,
  input logic mid
);

  logic [7:0] since_q;
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= 8'd0;
      age_q   <= 2'd0;
    end else begin
      since_q <= tick_o ? 8'd1 : ((since_q == 8'hff) ? since_q : since_q + 8'd1);
      age_q   <= (age_q == 2'd3) ? age_q : age_q + 2'd1;
    end
  end

  assert_out_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_o) |-> ($stable(sync_o) && $stable(mid)));

  assert_out_from_mid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_o) |-> (sync_o == $past(mid)));

  assert_full_rate_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_o) && age_q == 2'd3) |-> (mid == $past(async_i, 2)));

  assert_tick_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (since_q >= 8'd2));

  assert_tick_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R8: assert (!sync_o && !tick_o);
    end
  end

endmodule

bind divrate_sync divrate_sync_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .async_i(async_i),
  .tick_o (tick_o),
  .sync_o (sync_o),
  .mid    (mid_q)
);

// File: tb/divrate_sync_bench.sv
`timescale 1ns/1ps
module divrate_sync_bench;
  localparam int DIV_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             async_i = 1'b0;
  logic [DIV_W-1:0] div_sel = DIV_W'(4);
  logic             sync_o, tick_o;
  int               n_run = 0;
  int               n_fail = 0;
  bit               done = 0;

  always #5 clk = ~clk;

  divrate_sync #(.DIV_W(DIV_W), .RST_DIV(4)) u_divrate_sync (
    .clk_i(clk), .rst_ni(rst_n), .async_i(async_i),
    .div_sel_i(div_sel), .sync_o(sync_o), .tick_o(tick_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic to_tick();
    do @(negedge clk); while (!tick_o);
  endtask

  task automatic period(output int p);
    to_tick();
    p = 0;
    do begin @(negedge clk); p++; end while (!tick_o);
  endtask

  task automatic latency_case(input int n, input int q);
    logic old, nv;
    int   j;
    bit   bad;
    to_tick();
    repeat (q) @(negedge clk);
    old = sync_o;
    nv = ~old;
    async_i = nv;
    j = (q == 0) ? n : n - q;
    bad = 0;
    for (int off = 1; off <= j + n; off++) begin
      @(negedge clk);
      if (sync_o !== old) bad = 1;
    end
    check("R2 R5 output held before E(j+N)", int'(bad), 0);
    @(negedge clk);
    check((n == 4) ? "R6 output update edge" : "R5 output update edge", int'(sync_o), int'(nv));
  endtask

  initial begin
    int p, p2;
    bit seen;
    async_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 sync_o in reset", int'(sync_o), 0);
    check("R8 tick_o in reset", int'(tick_o), 0);
    async_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk); check("R8 no tick after 1st edge", int'(tick_o), 0);
    @(negedge clk); check("R8 no tick after 2nd edge", int'(tick_o), 0);
    @(negedge clk); check("R8 tick after 3rd edge", int'(tick_o), 1);
    check("R8 sync_o cleared", int'(sync_o), 0);

    for (int n = 0; n < (1 << DIV_W); n++) begin
      div_sel = DIV_W'(n);
      to_tick(); to_tick();
      period(p);
      check("R3 R4 tick period", p, (n < 2) ? 2 : n);
    end

    for (int n = 2; n < (1 << DIV_W); n++) begin
      div_sel = DIV_W'(n);
      to_tick(); to_tick();
      for (int q = 0; q < n; q++) begin
        latency_case(n, q);
        latency_case(n, q);
      end
    end

    div_sel = DIV_W'(4);
    to_tick(); to_tick();
    to_tick();
    repeat (3) @(negedge clk);
    async_i = 1'b1;
    @(negedge clk);
    async_i = 1'b0;
    for (int off = 2; off <= 6; off++) @(negedge clk);
    check("R1 pulse before divided edge passes", int'(sync_o), 1);
    to_tick();
    async_i = 1'b1;
    @(negedge clk);
    async_i = 1'b0;
    seen = 0;
    for (int off = 2; off <= 12; off++) begin
      @(negedge clk);
      if (sync_o) seen = 1;
    end
    check("R1 pulse on divided edge is lost", int'(seen), 0);

    div_sel = DIV_W'(3);
    to_tick(); to_tick();
    to_tick();
    @(negedge clk);
    div_sel = DIV_W'(6);
    p = 1;
    while (!tick_o) begin @(negedge clk); p++; end
    check("R7 old ratio finishes period", p, 3);
    p2 = 0;
    do begin @(negedge clk); p2++; end while (!tick_o);
    check("R7 new ratio after wrap", p2, 6);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule